// File: doc/BRIEF.md
# Oversampled Serial Receiver with Qualified Start Detection

This block receives asynchronous serial characters from a single line. The line is assumed to be already synchronised to the block clock. An external sample tick strobes the line eight times per bit. A character begins only after the line has been seen low on four consecutive ticks. The receiver then steps through the data bits, an optional parity bit and one stop bit. It takes each bit as the majority of three samples taken near the middle of the bit.

The finished character is checked for parity, framing, overrun and break conditions. It is copied into the holding buffer only when none of these occurred. A clean transfer raises a ready flag, and a one-cycle read strobe clears it. The error flags stay set until a clear pulse. Data length (5 to 8 bits, least significant bit first), parity enable and parity sense come from configuration inputs and are captured when a start is detected.

Top module: `uart_qrx`

## Requirements
- R1: A start is recognised only on the fourth consecutive tick that samples the line low, and only after the line was sampled high on some earlier tick. A low pulse of three ticks or less starts nothing.
- R2: Every bit spans 8 ticks. The first tick of the start bit is the first low tick. Each data, parity and stop bit takes the majority value of its 4th, 5th and 6th ticks, and all other ticks of the bit are ignored.
- R3: A length code of 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits, received least significant bit first. The buffer holds the character right-aligned, with its unused upper bits zero.
- R4: With parity enabled, the sense input at 1 requires an odd total of ones over data and parity bit, and at 0 an even total. A single flipped bit raises the parity flag, and two flipped bits pass.
- R5: A stop bit voted low raises the framing flag.
- R6: A character whose data, parity and stop bits all vote low raises the break flag together with the framing flag.
- R7: A character that completes while the ready flag is still set raises the overrun flag. The buffer keeps its old contents.
- R8: A character that raises any error flag is not transferred. The buffer and the ready flag stay as they were.
- R9: A clean character loads the buffer and sets the ready flag one clock after its last stop tick. A read strobe clears the ready flag.
- R10: Error flags stay set until the clear input is pulsed. The pulse clears all four flags.
- R11: While the receive enable is low, ticks are ignored and any character in progress is abandoned, so it produces no transfer and no error.
- R12: After a break the line must be seen high again before a new start can be recognised. A line that stays low therefore produces no further characters or flags.
- R13: After reset the buffer is zero and the ready flag and all error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial line, already synchronised |
| tick_i | input | 1 | Sample strobe, one clock wide, 8 per bit |
| rx_en_i | input | 1 | Receive enable |
| len_i | input | 2 | Data length code, 0..3 gives 5..8 bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 for odd parity, 0 for even |
| rd_i | input | 1 | Buffer read strobe, clears ready |
| err_clr_i | input | 1 | Clears all error flags |
| data_o | output | 8 | Holding buffer |
| ready_o | output | 1 | Buffer holds an unread character |
| err_parity_o | output | 1 | Sticky parity error |
| err_frame_o | output | 1 | Sticky framing error |
| err_overrun_o | output | 1 | Sticky overrun error |
| err_break_o | output | 1 | Sticky break |

## Verification
The hardest cases to reach from the ports involve individual ticks, not whole bits. One is a low glitch exactly one tick short of qualifying. Another is a line that stays low after a break and must not be taken as a fresh start. A third is a bit corrupted on one tick, or on two ticks, of its three-tick voting window. The bench therefore builds every frame tick by tick and can invert any chosen tick of any bit. This lets it place glitches inside and outside the window, stretch the line low across a whole character and beyond, and drop the enable in the middle of a character.

// File: rtl/uart_qrx_pkg.sv
// Shared types for the qualified-start serial receiver.
// Assumes nothing beyond IEEE 1800-2017 packages.
package uart_qrx_pkg;

    // Phases of one received character.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    // Per-character error conditions, reported at completion.
    typedef struct packed {
        logic brk;
        logic frame;
        logic overrun;
        logic parity;
    } rx_err_t;

endpackage

// File: rtl/qrx_start_qual.sv
// Start qualifier: raises start_o on the QUAL_TICKS-th consecutive low
// sample tick seen while the receiver is idle. The line must have been
// sampled high since the last start or since a low sample taken while
// busy, so a line held low after a break cannot retrigger.
// Assumes rx_i is synchronised and tick_i is one clock wide.
module qrx_start_qual #(
    parameter int QUAL_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_i,
    input  logic en_i,
    input  logic idle_i,
    output logic start_o
);
    localparam int CW = $clog2(QUAL_TICKS + 1);

    logic [CW-1:0] low_cnt;
    logic          armed;

    assign start_o = en_i && tick_i && idle_i && armed && !rx_i &&
                     (low_cnt == CW'(QUAL_TICKS - 1));

    // Track consecutive low ticks and whether a high level was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            armed   <= 1'b0;
        end else if (!en_i) begin
            low_cnt <= '0;
        end else if (tick_i) begin
            if (start_o) begin
                low_cnt <= '0;
                armed   <= 1'b0;
            end else if (rx_i) begin
                low_cnt <= '0;
                armed   <= 1'b1;
            end else if (idle_i && armed) begin
                low_cnt <= low_cnt + CW'(1);
            end else begin
                low_cnt <= '0;
                armed   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/qrx_bit_vote.sv
// Three-sample majority voter. Captures the line on the ticks whose
// in-bit phase equals FIRST, FIRST+1 and FIRST+2 and presents their
// majority on bit_o. Assumes the phase count is stable between ticks.
module qrx_bit_vote #(
    parameter int PW    = 3,
    parameter int FIRST = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [PW-1:0] phase_i,
    input  logic          rx_i,
    output logic          bit_o
);
    logic [2:0] smp;

    for (genvar g = 0; g < 3; g++) begin : g_smp
        // Hold the line value seen on voting tick g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                smp[g] <= 1'b1;
            else if (tick_i && phase_i == PW'(FIRST + g))
                smp[g] <= rx_i;
        end
    end

    assign bit_o = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
endmodule

// File: rtl/qrx_frame_ctrl.sv
// Character sequencer: steps start, data, optional parity and stop bit
// on sample ticks, shifts voted bits into the shift register LSB first
// and reports completion with the character and its error conditions.
// Assumes start_i arrives only in idle, with QUAL ticks of the start bit
// already consumed. Configuration is captured when the start is seen.
module qrx_frame_ctrl
    import uart_qrx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int MIN_BITS = 5,
    parameter int TPB      = 8,
    parameter int QUAL     = 4,
    parameter int LW       = 2,
    parameter int PW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic          start_i,
    input  logic          bit_i,
    input  logic [LW-1:0] len_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    input  logic          ready_i,
    output logic [PW-1:0] phase_o,
    output logic          idle_o,
    output logic          done_o,
    output logic          ok_o,
    output logic [DW-1:0] data_o,
    output rx_err_t       err_o
);
    localparam int          CW   = $clog2(DW + 1);
    localparam logic [PW-1:0] LAST = PW'(TPB - 1);

    rx_state_t     state;
    logic [PW-1:0] phase;
    logic [CW-1:0] bit_cnt;
    logic [CW-1:0] n_bits;
    logic          par_en_q;
    logic          par_odd_q;
    logic [DW-1:0] sh;
    logic          par_acc;
    logic          all_zero;
    logic          bit_end;

    assign bit_end = en_i && tick_i && (phase == LAST);
    assign phase_o = phase;
    assign idle_o  = (state == ST_IDLE);
    assign done_o  = bit_end && (state == ST_STOP);
    assign data_o  = sh >> (CW'(DW) - n_bits);

    // Classify the character from the stop vote and accumulated state.
    always_comb begin
        err_o.frame   = !bit_i;
        err_o.brk     = all_zero && !bit_i;
        err_o.parity  = par_en_q && (par_acc != par_odd_q);
        err_o.overrun = ready_i;
        ok_o          = done_o && !(|err_o);
    end

    // Sequence bits of one character and accumulate shift/parity/break state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= '0;
            bit_cnt   <= '0;
            n_bits    <= CW'(DW);
            par_en_q  <= 1'b0;
            par_odd_q <= 1'b0;
            sh        <= '0;
            par_acc   <= 1'b0;
            all_zero  <= 1'b0;
        end else if (!en_i) begin
            state <= ST_IDLE;
            phase <= '0;
        end else if (start_i) begin
            state     <= ST_START;
            phase     <= PW'(QUAL);
            bit_cnt   <= '0;
            n_bits    <= CW'(MIN_BITS) + CW'(len_i);
            par_en_q  <= par_en_i;
            par_odd_q <= par_odd_i;
            sh        <= '0;
            par_acc   <= 1'b0;
            all_zero  <= 1'b1;
        end else if (tick_i && state != ST_IDLE) begin
            phase <= (phase == LAST) ? '0 : phase + PW'(1);
            if (phase == LAST) begin
                unique case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        sh       <= {bit_i, sh[DW-1:1]};
                        par_acc  <= par_acc ^ bit_i;
                        all_zero <= all_zero & !bit_i;
                        bit_cnt  <= bit_cnt + CW'(1);
                        if (bit_cnt == n_bits - CW'(1))
                            state <= par_en_q ? ST_PAR : ST_STOP;
                    end
                    ST_PAR: begin
                        par_acc  <= par_acc ^ bit_i;
                        all_zero <= all_zero & !bit_i;
                        state    <= ST_STOP;
                    end
                    ST_STOP: begin
                        state <= ST_IDLE;
                        if (ok_o) sh <= '0;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R11: a low enable returns the sequencer to idle on the next clock.
    a_r11_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state == ST_IDLE);

    // R2: a start always lands mid start bit, never while busy.
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state == ST_START && phase == PW'(QUAL)));
endmodule

// File: rtl/uart_qrx.sv
// Top of the qualified-start serial receiver. Holds the receive buffer,
// the ready flag and the sticky error flags, and wires the start
// qualifier, bit voter and character sequencer together.
// Assumes a synchronised line and a one-clock sample tick, TPB per bit.
module uart_qrx
    import uart_qrx_pkg::*;
#(
    parameter int DW         = 8,
    parameter int MIN_BITS   = 5,
    parameter int TPB        = 8,
    parameter int QUAL_TICKS = 4,
    parameter int VOTE_FIRST = 3,
    parameter int LW         = $clog2(DW - MIN_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    input  logic          tick_i,
    input  logic          rx_en_i,
    input  logic [LW-1:0] len_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    input  logic          rd_i,
    input  logic          err_clr_i,
    output logic [DW-1:0] data_o,
    output logic          ready_o,
    output logic          err_parity_o,
    output logic          err_frame_o,
    output logic          err_overrun_o,
    output logic          err_break_o
);
    localparam int PW = $clog2(TPB);

    logic          start;
    logic          idle;
    logic          voted;
    logic          done;
    logic          ok;
    logic [PW-1:0] phase;
    logic [DW-1:0] char_data;
    rx_err_t       char_err;

    qrx_start_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_i),
        .en_i(rx_en_i), .idle_i(idle), .start_o(start)
    );

    qrx_bit_vote #(.PW(PW), .FIRST(VOTE_FIRST)) u_vote (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .phase_i(phase),
        .rx_i(rx_i), .bit_o(voted)
    );

    qrx_frame_ctrl #(
        .DW(DW), .MIN_BITS(MIN_BITS), .TPB(TPB), .QUAL(QUAL_TICKS),
        .LW(LW), .PW(PW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(rx_en_i),
        .start_i(start), .bit_i(voted), .len_i(len_i),
        .par_en_i(par_en_i), .par_odd_i(par_odd_i), .ready_i(ready_o),
        .phase_o(phase), .idle_o(idle), .done_o(done), .ok_o(ok),
        .data_o(char_data), .err_o(char_err)
    );

    // Load the buffer on a clean character; manage the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            ready_o <= 1'b0;
        end else if (ok) begin
            data_o  <= char_data;
            ready_o <= 1'b1;
        end else if (rd_i) begin
            ready_o <= 1'b0;
        end
    end

    // Latch error conditions of completed characters until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_parity_o  <= 1'b0;
            err_frame_o   <= 1'b0;
            err_overrun_o <= 1'b0;
            err_break_o   <= 1'b0;
        end else if (done) begin
            err_parity_o  <= err_parity_o  | char_err.parity;
            err_frame_o   <= err_frame_o   | char_err.frame;
            err_overrun_o <= err_overrun_o | char_err.overrun;
            err_break_o   <= err_break_o   | char_err.brk;
        end else if (err_clr_i) begin
            err_parity_o  <= 1'b0;
            err_frame_o   <= 1'b0;
            err_overrun_o <= 1'b0;
            err_break_o   <= 1'b0;
        end
    end

    // R8: a character with an error leaves the buffer untouched.
    a_r8_no_xfer_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |=> $stable(data_o));

    // R9: a read strobe without a concurrent transfer drops ready.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !ok) |=> !ready_o);

    // R7: completing while ready is held flags an overrun.
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ready_o) |=> err_overrun_o);

    // R10: flags persist without a clear pulse.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame_o && !err_clr_i) |=> err_frame_o);

    // R6: a break is always reported together with a framing error.
    a_r6_break_frames: assert property (@(posedge clk) disable iff (!rst_n)
        err_break_o |-> err_frame_o);
endmodule

// File: tb/test_uart_qrx.sv
`timescale 1ns/1ps
module test_uart_qrx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       rx_en_i = 1'b1;
    logic [1:0] len_i = 2'd3;
    logic       par_en_i = 1'b0;
    logic       par_odd_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       err_clr_i = 1'b0;
    logic [7:0] data_o;
    logic       ready_o, err_parity_o, err_frame_o, err_overrun_o, err_break_o;

    int checks = 0;
    int bad = 0;
    logic [7:0] exp_buf = 8'h00;

    always #5 clk = ~clk;

    uart_qrx i_uart_qrx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick_i),
        .rx_en_i(rx_en_i), .len_i(len_i), .par_en_i(par_en_i),
        .par_odd_i(par_odd_i), .rd_i(rd_i), .err_clr_i(err_clr_i),
        .data_o(data_o), .ready_o(ready_o), .err_parity_o(err_parity_o),
        .err_frame_o(err_frame_o), .err_overrun_o(err_overrun_o),
        .err_break_o(err_break_o)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {err_break_o, err_frame_o, err_overrun_o, err_parity_o};
        chk(act == exp, req, act, exp);
    endtask

    // One sample tick carrying line level b; ticks are 4 clocks apart.
    task automatic tk(input logic b);
        @(negedge clk); rx_i = b; tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One bit time; tick i carries b inverted where gmask[i] is set.
    task automatic send_bit(input logic b, input logic [7:0] gmask);
        for (int i = 0; i < 8; i++) tk(b ^ gmask[i]);
    endtask

    function automatic int nbits();
        return 5 + int'(len_i);
    endfunction

    function automatic logic [7:0] lenmask();
        return 8'((1 << nbits()) - 1);
    endfunction

    // Parity bit that makes the original data satisfy the selected sense.
    function automatic logic par_of(input logic [7:0] d);
        return (^(d & lenmask())) ^ par_odd_i;
    endfunction

    // Voted value of a bit whose ticks are inverted by gmask.
    function automatic logic voted(input logic b, input logic [7:0] gmask);
        return b ^ (int'(gmask[3]) + int'(gmask[4]) + int'(gmask[5]) >= 2);
    endfunction

    // Full character: idle, start, data (with flips and one glitched bit),
    // parity computed from d, stop level, trailing idle.
    task automatic send_frame(input logic [7:0] d, input logic [7:0] flip,
                              input logic stop_v, input int gbit,
                              input logic [7:0] gmask);
        logic [7:0] tx;
        tx = d ^ flip;
        repeat (4) tk(1'b1);
        send_bit(1'b0, 8'h00);
        for (int i = 0; i < nbits(); i++)
            send_bit(tx[i], (i == gbit) ? gmask : 8'h00);
        if (par_en_i) send_bit(par_of(d), 8'h00);
        send_bit(stop_v, 8'h00);
        repeat (2) tk(1'b1);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_i = 1'b1;
        @(negedge clk); rd_i = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr_i = 1'b1;
        @(negedge clk); err_clr_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        chk(data_o == 8'h00, "R13 buffer", data_o, 0);
        chk(ready_o == 1'b0, "R13 ready", ready_o, 0);
        chk_flags("R13 flags", 4'b0000);

        // R9/R3: clean 8-bit character, then read
        send_frame(8'hC3, 8'h00, 1'b1, -1, 8'h00);
        chk(ready_o, "R9 ready set", ready_o, 1);
        chk(data_o == 8'hC3, "R3 8-bit data", data_o, 8'hC3);
        pulse_rd();
        chk(!ready_o, "R9 read clears", ready_o, 0);

        // R3: 5-bit length keeps upper bits zero
        len_i = 2'd0;
        send_frame(8'hFF, 8'h00, 1'b1, -1, 8'h00);
        chk(data_o == 8'h1F, "R3 5-bit right aligned", data_o, 8'h1F);
        pulse_rd();

        // R1: three-tick low glitch does not start a character
        len_i = 2'd3;
        repeat (4) tk(1'b1);
        repeat (3) tk(1'b0);
        repeat (20) tk(1'b1);
        chk(!ready_o, "R1 short glitch ignored", ready_o, 0);
        chk_flags("R1 no flags after glitch", 4'b0000);
        send_frame(8'h96, 8'h00, 1'b1, -1, 8'h00);
        chk(ready_o && data_o == 8'h96, "R1 frame after glitch", data_o, 8'h96);
        pulse_rd();

        // R2: single tick inside window, and ticks outside window, ignored
        send_frame(8'hA5, 8'h00, 1'b1, 1, 8'b0000_1000);
        chk(data_o == 8'hA5, "R2 one window tick", data_o, 8'hA5);
        pulse_rd();
        send_frame(8'hA5, 8'h00, 1'b1, 1, 8'b1100_0111);
        chk(data_o == 8'hA5, "R2 outside window", data_o, 8'hA5);
        pulse_rd();
        // R2: two window ticks flip the bit
        send_frame(8'hA5, 8'h00, 1'b1, 1, 8'b0011_0000);
        chk(data_o == {7'h53, voted(1'b0, 8'b0011_0000)} ^ 8'h00 && data_o == 8'hA7,
            "R2 majority flips", data_o, 8'hA7);
        pulse_rd();

        // R4: odd parity, single flip -> error, no transfer (R8)
        par_en_i = 1'b1; par_odd_i = 1'b1;
        send_frame(8'h4D, 8'h08, 1'b1, -1, 8'h00);
        chk(err_parity_o, "R4 single flip flagged", err_parity_o, 1);
        chk(!ready_o && data_o == 8'hA7, "R8 no transfer on parity", data_o, 8'hA7);
        pulse_clr();
        chk_flags("R10 clear pulse", 4'b0000);
        // R4: two flips pass parity
        send_frame(8'h4D, 8'h09, 1'b1, -1, 8'h00);
        chk_flags("R4 double flip passes", 4'b0000);
        chk(data_o == 8'h44, "R4 double flip data", data_o, 8'h44);
        pulse_rd();

        // R5/R10: framing error, sticky across a clean character
        par_en_i = 1'b0;
        send_frame(8'h3C, 8'h00, 1'b0, -1, 8'h00);
        chk_flags("R5 framing", 4'b0100);
        chk(!ready_o && data_o == 8'h44, "R8 no transfer on framing", data_o, 8'h44);
        send_frame(8'h21, 8'h00, 1'b1, -1, 8'h00);
        chk_flags("R10 framing sticky", 4'b0100);
        chk(data_o == 8'h21, "R9 clean after error", data_o, 8'h21);

        // R7: second character while ready still set
        send_frame(8'h22, 8'h00, 1'b1, -1, 8'h00);
        chk(err_overrun_o, "R7 overrun flagged", err_overrun_o, 1);
        chk(data_o == 8'h21 && ready_o, "R7 buffer kept", data_o, 8'h21);
        pulse_rd();
        pulse_clr();

        // R6/R12: break, then line stays low
        par_en_i = 1'b1; par_odd_i = 1'b0;
        repeat (4) tk(1'b1);
        repeat ((1 + 8 + 1 + 1) * 8) tk(1'b0);
        chk_flags("R6 break plus framing", 4'b1100);
        chk(!ready_o, "R6 no transfer", ready_o, 0);
        pulse_clr();
        repeat (60) tk(1'b0);
        chk_flags("R12 held low no retrigger", 4'b0000);
        chk(!ready_o, "R12 no character", ready_o, 0);
        send_frame(8'h5B, 8'h00, 1'b1, -1, 8'h00);
        chk(ready_o && data_o == 8'h5B, "R12 resumes after high", data_o, 8'h5B);
        pulse_rd();

        // R11: whole character while disabled
        par_en_i = 1'b0;
        rx_en_i = 1'b0;
        send_frame(8'h77, 8'h00, 1'b1, -1, 8'h00);
        chk(!ready_o && data_o == 8'h5B, "R11 disabled ignored", data_o, 8'h5B);
        // R11: abort mid character
        rx_en_i = 1'b1;
        repeat (4) tk(1'b1);
        send_bit(1'b0, 8'h00);
        send_bit(1'b1, 8'h00);
        send_bit(1'b1, 8'h00);
        rx_en_i = 1'b0;
        repeat (6) send_bit(1'b0, 8'h00);
        send_bit(1'b0, 8'h00);
        chk(!ready_o, "R11 abort no transfer", ready_o, 0);
        chk_flags("R11 abort no flags", 4'b0000);
        rx_en_i = 1'b1;
        send_frame(8'h5A, 8'h00, 1'b1, -1, 8'h00);
        chk(data_o == 8'h5A, "R11 recovers", data_o, 8'h5A);
        pulse_rd();

        // Random clean characters across lengths and parity settings
        for (int n = 0; n < 30; n++) begin
            len_i     = 2'($urandom % 4);
            par_en_i  = 1'($urandom % 2);
            par_odd_i = 1'($urandom % 2);
            d         = 8'($urandom);
            send_frame(d, 8'h00, 1'b1, -1, 8'h00);
            exp_buf = d & lenmask();
            chk(ready_o && data_o == exp_buf, "R3 random data", data_o, exp_buf);
            chk_flags("R4 random no error", 4'b0000);
            pulse_rd();
        end

        finish_run();
    end
endmodule